// File: doc/BRIEF.md
# Programmable-Period Watchdog Timer

This block supervises software. It counts a slow tick that is free of the system clock. If software does not restart it in time, it raises a reset request. An 8-bit control byte selects the timeout period, turns the timer on or off, and holds a self-clearing restart bit. The period is 16 ticks at the shortest setting and doubles with each step of a 3-bit period field, up to 2048 ticks. With a 1 ms tick this gives a range of 16 ms to 2048 ms.

Software writes the control byte through a simple write strobe and can read it back at any time. The independent oscillator is outside this block; a one-cycle `tick_en` strobe stands in for each of its ticks. While the chip is in power-down, the timer is held off and its count stays at zero. Power-on reset leaves the timer disabled.

Top module: `prog_watchdog`

## Requirements
- R1: After synchronous reset (`rst_n` low at a clock edge), the control readback is 0x00, the timer is disabled, and `wdt_rst` stays low until software enables it.
- R2: Control byte layout: bits 7:5 are the period code, bit 2 is the data-pointer select, bit 1 is restart, and bit 0 is enable. The readback shows code, select and enable in those positions. Bits 4:3 and bit 1 always read 0. A write is visible on `ctrl_rd` in the cycle after its clock edge.
- R3: With period code P, a timeout occurs on the (16 << P)-th counted tick after the count was last zero.
- R4: A timeout raises `wdt_rst` for exactly one clock cycle. Counting then resumes from zero, so an unattended timer fires every 16 << P ticks.
- R5: A write with bit 1 set restarts the count. The count is zero after the following clock edge, and ticks count again from the edge after that. The bit reads back as 0.
- R6: A write that changes the period code restarts the count in the same way as R5, even when bit 1 is 0.
- R7: With enable at 0 the count is held at zero and no timeout occurs. Enabling again without a restart counts from zero, starting with the tick at the next edge.
- R8: While `pwr_down` is high, the count is held at zero and no timeout occurs. The enable setting is kept. After `pwr_down` falls, counting starts from zero.
- R9: The count advances only at clock edges where `tick_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low power-on reset |
| wr_en | input | 1 | Control byte write strobe |
| wr_data | input | 8 | Control byte write data |
| tick_en | input | 1 | One-cycle strobe per watchdog tick |
| pwr_down | input | 1 | High while the chip is in power-down |
| ctrl_rd | output | 8 | Control byte readback |
| wdt_rst | output | 1 | One-cycle reset request on timeout |

## Verification
Timing is counted from the clock edge that takes a write.

- **Restart write:** `ctrl_rd` changes after that edge W. The count is cleared at W+1, so with a tick on every cycle the reset request appears after edge W+1+(16<<P).
- **Timer re-enabled or power-down released, no restart:** the first tick is counted at the next edge E, so the request follows edge E+(16<<P)-1.

The driver computes each of these due edges and queues it together with its requirement tag. The monitor samples on the falling edge. It expects `wdt_rst` high exactly at each queued edge and low at every other edge.

// File: rtl/wdt_pkg.sv
// Shared constants and types for the programmable watchdog.
// Assumes an 8-bit control byte. The field positions below are decoded
// by software, so they are fixed.
package wdt_pkg;
    localparam int CTRL_W    = 8;
    localparam int PS_W      = 3;
    localparam int PS_LO     = 5;
    localparam int PS_HI     = PS_LO + PS_W - 1;
    localparam int DPS_BIT   = 2;
    localparam int KICK_BIT  = 1;
    localparam int EN_BIT    = 0;
    localparam int NUM_STEPS = 1 << PS_W;

    typedef struct packed {
        logic [PS_W-1:0] ps;
        logic            dps;
        logic            en;
    } wdt_ctrl_t;
endpackage

// File: rtl/wdt_ctrl_reg.sv
// Control byte holder. It stores the period code, the data-pointer select
// and the enable. It turns a restart-bit write or a period change into a
// one-cycle restart pulse. Assumes writes are single-cycle strobes.
module wdt_ctrl_reg
    import wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    output wdt_ctrl_t         ctrl,
    output logic              kick,
    output logic [CTRL_W-1:0] rd_data
);
    logic unused_rsvd;
    assign unused_rsvd = ^wr_data[PS_LO-1:DPS_BIT+1];

    // Capture fields on a write; restart pulse lasts one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl <= '0;
            kick <= 1'b0;
        end else begin
            kick <= wr_en && (wr_data[KICK_BIT] || (wr_data[PS_HI:PS_LO] != ctrl.ps));
            if (wr_en) begin
                ctrl.ps  <= wr_data[PS_HI:PS_LO];
                ctrl.dps <= wr_data[DPS_BIT];
                ctrl.en  <= wr_data[EN_BIT];
            end
        end
    end

    // Readback: reserved and restart positions read as zero.
    always_comb begin
        rd_data              = '0;
        rd_data[PS_HI:PS_LO] = ctrl.ps;
        rd_data[DPS_BIT]     = ctrl.dps;
        rd_data[EN_BIT]      = ctrl.en;
    end
endmodule

// File: rtl/wdt_period_sel.sv
// Maps the period code to the terminal count (ticks minus one).
// Each step doubles the base period. The table is built by a generate
// loop, so it has one entry per code.
module wdt_period_sel
    import wdt_pkg::*;
#(
    parameter int BASE_TICKS = 16,
    parameter int CNT_W      = 12
) (
    input  logic [PS_W-1:0]  ps,
    output logic [CNT_W-1:0] limit_m1
);
    logic [CNT_W-1:0] lut [NUM_STEPS];

    for (genvar i = 0; i < NUM_STEPS; i++) begin : g_step
        assign lut[i] = CNT_W'((BASE_TICKS << i) - 1);
    end

    // Select the terminal count for the current code.
    assign limit_m1 = lut[ps];
endmodule

// File: rtl/wdt_counter.sv
// Tick counter with terminal detection.
// Priority: not running, then restart, then timeout, then count.
// Assumes tick is a one-cycle strobe.
module wdt_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit_m1,
    output logic [CNT_W-1:0] cnt,
    output logic             fire
);
    // Advance on ticks; fire and wrap at the terminal count.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else if (restart) begin
            cnt  <= '0;
            fire <= 1'b0;
        end else if (tick && (cnt == limit_m1)) begin
            cnt  <= '0;
            fire <= 1'b1;
        end else begin
            if (tick) begin
                cnt <= cnt + 1'b1;
            end
            fire <= 1'b0;
        end
    end
endmodule

// File: rtl/prog_watchdog.sv
// Programmable-period watchdog top.
// It runs while enabled and not in power-down. It requests a one-cycle
// reset when the selected number of ticks passes without a restart.
module prog_watchdog
    import wdt_pkg::*;
#(
    parameter int BASE_TICKS = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [CTRL_W-1:0] wr_data,
    input  logic              tick_en,
    input  logic              pwr_down,
    output logic [CTRL_W-1:0] ctrl_rd,
    output logic              wdt_rst
);
    localparam int MAX_TICKS = BASE_TICKS << (NUM_STEPS - 1);
    localparam int CNT_W     = $clog2(MAX_TICKS) + 1;

    wdt_ctrl_t        ctrl;
    logic             kick;
    logic             run;
    logic [CNT_W-1:0] limit_m1;
    logic [CNT_W-1:0] cnt;

    wdt_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_data (wr_data),
        .ctrl    (ctrl),
        .kick    (kick),
        .rd_data (ctrl_rd)
    );

    wdt_period_sel #(.BASE_TICKS(BASE_TICKS), .CNT_W(CNT_W)) u_sel (
        .ps       (ctrl.ps),
        .limit_m1 (limit_m1)
    );

    // Timer runs only when enabled and out of power-down.
    assign run = ctrl.en && !pwr_down;

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .restart  (kick),
        .tick     (tick_en),
        .limit_m1 (limit_m1),
        .cnt      (cnt),
        .fire     (wdt_rst)
    );
endmodule

// File: rtl/wdt_checker.sv
// Concurrent properties for prog_watchdog, attached by bind.
module wdt_checker #(
    parameter int CNT_W = 12
) (
    input logic             clk,
    input logic             rst_n,
    input logic             wr_en,
    input logic [7:0]       wr_data,
    input logic             pwr_down,
    input logic [7:0]       ctrl_rd,
    input logic             wdt_rst,
    input logic             kick,
    input logic [CNT_W-1:0] cnt,
    input logic [CNT_W-1:0] limit_m1
);
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wdt_rst |=> !wdt_rst);

    p_off_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_rd[0] |=> !wdt_rst);

    p_pd_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_down |=> !wdt_rst);

    p_restart_holds_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_data[1]) |=> ##1 !wdt_rst);

    p_ctrl_stable_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(ctrl_rd));

    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !kick |-> (cnt <= limit_m1));
endmodule

bind prog_watchdog wdt_checker #(.CNT_W(CNT_W)) u_wdt_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .pwr_down (pwr_down),
    .ctrl_rd  (ctrl_rd),
    .wdt_rst  (wdt_rst),
    .kick     (kick),
    .cnt      (cnt),
    .limit_m1 (limit_m1)
);

// File: tb/tb_prog_watchdog.sv
module tb_prog_watchdog;
    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       tick_en = 1'b1;
    logic       pwr_down = 1'b0;
    logic [7:0] ctrl_rd;
    logic       wdt_rst;

    int cyc = 0;
    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    typedef struct {
        int    due;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    prog_watchdog dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .tick_en(tick_en), .pwr_down(pwr_down), .ctrl_rd(ctrl_rd), .wdt_rst(wdt_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h (edge %0d)", tag, act, expv, cyc);
        end
    endtask

    task automatic push(input int due, input string tag);
        exp_t e;
        e.due = due;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic write_ctrl(input logic [7:0] d, output int w);
        @(negedge clk);
        wr_en = 1'b1;
        wr_data = d;
        w = cyc + 1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    // Monitor: compares each edge's reset request against the queue.
    always @(negedge clk) begin
        if (!done && rst_n) begin
            if (exp_q.size() > 0 && cyc == exp_q[0].due) begin
                check(wdt_rst == 1'b1, exp_q[0].tag, wdt_rst, 1);
                void'(exp_q.pop_front());
            end else if (wdt_rst) begin
                check(1'b0, "unexpected pulse R3/R7/R8", 1, 0);
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: bench hung, actual running expected done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        int w, k, p;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check(ctrl_rd == 8'h00, "R1 readback", ctrl_rd, 8'h00);
        check(wdt_rst == 1'b0, "R1 pulse", wdt_rst, 0);
        repeat (30) @(negedge clk);

        // R3/R4: code 0, fires every 16 ticks
        write_ctrl(8'h03, w);
        check(ctrl_rd == 8'h01, "R2 enable readback", ctrl_rd, 8'h01);
        push(w + 17, "R3 first timeout code0");
        push(w + 33, "R4 periodic timeout");
        wait_until(w + 40);
        write_ctrl(8'h00, w);
        wait_until(w + 100);

        // R5: restart postpones timeout; bit reads 0
        write_ctrl(8'h23, w);
        wait_until(w + 20);
        write_ctrl(8'h23, k);
        check(ctrl_rd == 8'h21, "R5 restart reads 0", ctrl_rd, 8'h21);
        push(k + 33, "R5 restart timing code1");
        wait_until(k + 40);
        write_ctrl(8'h00, w);
        wait_until(w + 60);

        // R6: period change restarts count
        write_ctrl(8'h43, w);
        wait_until(w + 30);
        write_ctrl(8'h61, k);
        push(k + 129, "R6 change code restarts");
        wait_until(k + 135);
        write_ctrl(8'h00, w);
        wait_until(w + 20);

        // R3: largest code
        write_ctrl(8'hE3, w);
        push(w + 2049, "R3 code7 2048 ticks");
        wait_until(w + 2055);
        write_ctrl(8'h00, w);
        wait_until(w + 20);

        // R8: power-down holds count at zero
        write_ctrl(8'h03, w);
        wait_until(w + 5);
        pwr_down = 1'b1;
        wait_until(w + 105);
        check(ctrl_rd == 8'h01, "R8 enable kept", ctrl_rd, 8'h01);
        pwr_down = 1'b0;
        p = cyc + 1;
        push(p + 15, "R8 fresh count after power-down");
        wait_until(p + 20);
        write_ctrl(8'h00, w);
        wait_until(w + 20);

        // R9: no ticks, no progress
        tick_en = 1'b0;
        write_ctrl(8'h03, w);
        wait_until(w + 40);
        tick_en = 1'b1;
        p = cyc + 1;
        push(p + 15, "R9 count only on ticks");
        wait_until(p + 20);
        write_ctrl(8'h00, w);
        wait_until(w + 20);

        // R7: disable clears count; re-enable without restart
        write_ctrl(8'h03, w);
        wait_until(w + 10);
        write_ctrl(8'h00, w);
        wait_until(w + 5);
        write_ctrl(8'h01, k);
        push(k + 16, "R7 re-enable counts from zero");
        wait_until(k + 20);
        write_ctrl(8'h00, w);
        wait_until(w + 20);

        // R2: reserved bits read 0, select bit kept
        write_ctrl(8'h1C, w);
        check(ctrl_rd == 8'h04, "R2 reserved read 0", ctrl_rd, 8'h04);
        write_ctrl(8'hFF, w);
        check(ctrl_rd == 8'hE5, "R2 full layout", ctrl_rd, 8'hE5);
        write_ctrl(8'h00, w);
        wait_until(w + 50);

        // R1: reset mid-run disables
        write_ctrl(8'h03, w);
        wait_until(w + 8);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        check(ctrl_rd == 8'h00, "R1 reset mid-run", ctrl_rd, 8'h00);
        repeat (40) @(negedge clk);

        check(exp_q.size() == 0, "R4 all timeouts seen", exp_q.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule